// File: doc/BRIEF.md
# Handshaked Serial Word Streamer

This block moves 16-bit words from an on-chip word source out to an external host over a three-wire link: a request line, a serial clock and a serial data line. The host raises the request when it is ready to receive. The block then sends each word one bit at a time, MSB first. The words come from a valid/ready source, and only whole words are ever sent.

The serial clock can come from either side. In the two external-clock modes the host drives the clock, and the block moves its data on one edge so that the host can sample on the opposite edge. In the internal-clock mode the block generates the clock from the system clock with a programmable divider. In that mode the block observes a fixed lead-in of 32 clock periods after the request rises, and a fixed run-out of 32 clock periods after the request falls. The host clock and the request pass through two-flop synchronisers before any edge is detected. A configuration write selects the mode and the divider, and it only takes effect while the link is idle.

Top module: `hs_word_streamer`

## Requirements
- R1: After reset, `sdata_out` is 0, `sclk_out` is 1, `word_ready` is 0 and `sclk_oe` is 0. The reset mode code is 00 and the reset divider is 3.
- R2: Each accepted word is sent MSB first in exactly 16 bit slots. Words are taken one at a time through `word_valid`/`word_ready`, in source order, and back to back.
- R3: Mode code 00 (external clock, idling low): `sdata_out` takes its next bit only after a synchronised rising edge of `sclk_in`, and it holds that bit across the following falling edge, where the host samples.
- R4: Mode code 01 (external clock, idling high): `sdata_out` takes its next bit only after a synchronised falling edge of `sclk_in`, and it holds that bit across the following rising edge, where the host samples.
- R5: Mode codes 10 and 11 (bit 1 of `cfg_mode` set): `sclk_oe` is 1 and the block drives `sclk_out`. The clock parks high, data bits change only together with a falling edge, and each half period lasts `cfg_div`+1 system cycles. While `sclk_oe` is 0, `sclk_out` stays 1.
- R6: Internal clock: the first falling edge after `req_in` rises comes no earlier than 64*(`cfg_div`+1) system cycles (32 generated periods) and no later than 66*(`cfg_div`+1)+4 cycles.
- R7: Internal clock: after `req_in` falls with no word in flight, the clock stays high and the engine stays busy for 32 generated periods before it returns to idle. A pending configuration therefore takes effect between 64*(`cfg_div`+1) and 66*(`cfg_div`+1)+8 cycles after the fall.
- R8: With the request high and the source empty, the internal clock makes no falling edge. In the external modes, each shifting edge drives `sdata_out` to 0 and takes no word.
- R9: A `cfg_wr` write is held pending. It is copied into use only while the synchronised request is low and the engine is idle. A write made while the request is high leaves `sclk_oe` unchanged.
- R10: If the request falls in the middle of a word, that word still completes and no further word is taken. In the external modes, the engine goes idle at the first shifting edge after the word ends, and drives `sdata_out` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the pending configuration |
| cfg_mode | input | 2 | Mode code: 00 external idle-low, 01 external idle-high, 1x internal clock |
| cfg_div | input | DIV_W | Internal clock half period minus one, in system cycles |
| word_data | input | W | Word offered by the source |
| word_valid | input | 1 | Source has a word |
| word_ready | output | 1 | Block takes the offered word at this edge |
| req_in | input | 1 | Host request, asynchronous |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| sclk_out | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for the generated clock (internal mode) |
| sdata_out | output | 1 | Serial data to the host |

## Verification
The bench builds the block with the default parameters: 16-bit words, an 8-bit divider field and a 32-period lead and run-out. At run time it programs divider values 2 and 0, so that the latency windows of R6 and R7 can be checked at two half-period lengths, and so that the mode-11 alias is reached. The host clock is modelled with a half period of six system cycles, which is long enough to cover the synchroniser path. This lets the bench check that data holds steady through each sampling edge. Tests that drop the request mid-word and that leave the source empty cover the whole-word rule and the idle data level.

// File: rtl/hs_stream_pkg.sv
package hs_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } stream_st_e;

  localparam int MODE_W        = 2;
  localparam int MODE_BIT_INT  = 1;  // set: block generates the clock
  localparam int MODE_BIT_FALL = 0;  // external: shift on falling edge
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_tick_gen.sv
module hs_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)     cnt <= '0;
    else if (cnt == div) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  // one tick per generated half period
  assign tick = run && (cnt == div);
endmodule

// File: rtl/hs_shift_core.sv
module hs_shift_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         clear,
  input  logic [W-1:0] din,
  output logic         sdata,
  output logic         busy
);
  localparam int CNT_W = $clog2(W);

  logic [W-1:0]     sreg;
  logic [CNT_W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      sreg  <= '0;
      left  <= '0;
      sdata <= 1'b0;
    end else if (load) begin
      sdata <= din[W-1];
      sreg  <= {din[W-2:0], 1'b0};
      left  <= CNT_W'(W-1);
    end else if (shift) begin
      sdata <= sreg[W-1];
      sreg  <= {sreg[W-2:0], 1'b0};
      left  <= left - 1'b1;
    end else if (clear) begin
      sdata <= 1'b0;
    end
  end

  assign busy = (left != '0);
endmodule

// File: rtl/hs_word_streamer.sv
module hs_word_streamer
  import hs_stream_pkg::*;
#(
  parameter int              W           = 16,
  parameter int              DIV_W       = 8,
  parameter int              LAT_PERIODS = 32,
  parameter int              SYNC_STAGES = 2,
  parameter logic [1:0]      MODE_RST    = 2'b00,
  parameter logic [DIV_W-1:0] DIV_RST    = DIV_W'(3)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_mode,
  input  logic [DIV_W-1:0] cfg_div,
  input  logic [W-1:0]     word_data,
  input  logic             word_valid,
  output logic             word_ready,
  input  logic             req_in,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             sdata_out
);
  localparam int LAT_TICKS = 2 * LAT_PERIODS;
  localparam int LCNT_W    = $clog2(LAT_TICKS);

  logic              req_sync, sclk_sync, sclk_prev;
  logic [1:0]        sync_q;
  logic [MODE_W-1:0] mode_p, mode_a;
  logic [DIV_W-1:0]  div_p, div_a;
  stream_st_e        st;
  logic [LCNT_W-1:0] lcnt;
  logic              sclk_q;
  logic              tick, int_mode, ext_edge, step, take, busy;

  hs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d({req_in, sclk_in}), .q(sync_q)
  );
  assign req_sync  = sync_q[1];
  assign sclk_sync = sync_q[0];

  assign int_mode = mode_a[MODE_BIT_INT];
  assign ext_edge = mode_a[MODE_BIT_FALL] ? (sclk_prev & ~sclk_sync)
                                          : (sclk_sync & ~sclk_prev);

  hs_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst(rst),
    .run(int_mode && (st != ST_IDLE)),
    .div(div_a), .tick(tick)
  );

  // a shifting opportunity: internal clock high at a tick, or external edge
  assign step       = (st == ST_RUN) && (int_mode ? (tick && sclk_q) : ext_edge);
  assign word_ready = step && !busy && req_sync;
  assign take       = word_ready && word_valid;

  hs_shift_core #(.W(W)) core_i (
    .clk(clk), .rst(rst),
    .load(take),
    .shift(step && busy),
    .clear(step && !busy && !take),
    .din(word_data),
    .sdata(sdata_out),
    .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      lcnt      <= '0;
      sclk_q    <= 1'b1;
      sclk_prev <= 1'b0;
      mode_p    <= MODE_RST;
      mode_a    <= MODE_RST;
      div_p     <= DIV_RST;
      div_a     <= DIV_RST;
    end else begin
      sclk_prev <= sclk_sync;
      if (cfg_wr) begin
        mode_p <= cfg_mode;
        div_p  <= cfg_div;
      end
      if ((st == ST_IDLE) && !req_sync) begin
        mode_a <= mode_p;
        div_a  <= div_p;
      end
      case (st)
        ST_IDLE: begin
          lcnt <= '0;
          if (req_sync) st <= int_mode ? ST_LEAD : ST_RUN;
        end
        ST_LEAD: begin
          if (!req_sync) begin
            st <= ST_IDLE;
          end else if (tick) begin
            if (lcnt == LCNT_W'(LAT_TICKS-1)) begin
              st   <= ST_RUN;
              lcnt <= '0;
            end else begin
              lcnt <= lcnt + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (step) begin
            if (int_mode) sclk_q <= !(busy || take);
            if (!busy && !req_sync) begin
              st   <= int_mode ? ST_TAIL : ST_IDLE;
              lcnt <= '0;
            end
          end else if (int_mode && tick && !sclk_q) begin
            sclk_q <= 1'b1;
          end
        end
        ST_TAIL: begin
          if (tick) begin
            if (lcnt == LCNT_W'(LAT_TICKS-1)) st <= ST_IDLE;
            else                               lcnt <= lcnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sclk_out = sclk_q;
  assign sclk_oe  = int_mode;
endmodule

// File: rtl/hs_stream_chk.sv
module hs_stream_chk (
  input logic clk,
  input logic rst,
  input logic req_sync,
  input logic sclk_oe,
  input logic sclk_out,
  input logic sdata_out,
  input logic word_valid,
  input logic word_ready,
  input logic word_msb,
  input logic core_busy
);
  // R2
  msb_first_chk: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_ready) |=> (sdata_out == $past(word_msb)));

  // R5
  rise_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe && $past(sclk_oe) && $rose(sdata_out)) |-> $fell(sclk_out));

  // R5
  ext_park_chk: assert property (@(posedge clk) disable iff (rst)
    (!sclk_oe) |-> sclk_out);

  // R9
  cfg_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_oe != $past(sclk_oe)) |-> !$past(req_sync));

  // R8
  fall_has_bit_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sclk_out) && !$past(core_busy)) |-> $past(word_valid && word_ready));
endmodule

bind hs_word_streamer hs_stream_chk chk_i (
  .clk(clk),
  .rst(rst),
  .req_sync(req_sync),
  .sclk_oe(sclk_oe),
  .sclk_out(sclk_out),
  .sdata_out(sdata_out),
  .word_valid(word_valid),
  .word_ready(word_ready),
  .word_msb(word_data[W-1]),
  .core_busy(busy)
);

// File: tb/hs_word_streamer_tb_top.sv
module hs_word_streamer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 16;
  localparam int DIV_W      = 8;
  localparam int HALF       = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [W-1:0] word_data = '0;
  logic word_valid = 1'b0, word_ready;
  logic req_in = 1'b0, sclk_in = 1'b0;
  logic sclk_out, sclk_oe, sdata_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [W-1:0] src_q[$];
  logic [W-1:0] exp_q[$];
  logic [W-1:0] acc = '0;
  int nb = 0;
  bit pend = 0, mon_prev = 1;
  string cur_req = "R5";

  hs_word_streamer #(.W(W), .DIV_W(DIV_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_div(cfg_div),
    .word_data(word_data), .word_valid(word_valid), .word_ready(word_ready),
    .req_in(req_in), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdata_out(sdata_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor side of the scoreboard: assemble bits, compare whole words
  task automatic collect(bit b, string req);
    logic [W-1:0] e;
    acc = {acc[W-2:0], b};
    nb++;
    if (nb == W) begin
      nb = 0;
      if (exp_q.size() == 0) check(0, req, "unexpected word", int'(acc), 0);
      else begin
        e = exp_q.pop_front();
        check(acc == e, req, "word", int'(acc), int'(e));
      end
    end
  endtask

  // driver side: expected item and source item pushed together
  task automatic push_word(logic [W-1:0] w);
    @(posedge clk);
    src_q.push_back(w);
    exp_q.push_back(w);
  endtask

  // word source model: the handshake seen at one negedge completes at the next posedge
  always @(negedge clk) begin
    if (pend && src_q.size() > 0) src_q.delete(0);
    word_valid = (src_q.size() > 0);
    word_data  = word_valid ? src_q[0] : '0;
    pend       = word_valid && word_ready;
  end

  // generated-clock host: samples on the rising edge
  always @(negedge clk) begin
    if (sclk_oe && !mon_prev && sclk_out) collect(sdata_out, cur_req);
    mon_prev = sclk_out;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic set_cfg(logic [1:0] m, logic [DIV_W-1:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_mode = m; cfg_div = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // external-clock host: change edge, wait, sample edge, wait
  task automatic ext_bits(int n, bit coll, bit idle_hi, string req);
    bit b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sclk_in = !idle_hi;
      repeat (HALF) @(negedge clk);
      b = sdata_out;
      sclk_in = idle_hi;
      if (coll) collect(b, req);
      else check(b == 1'b0, "R8", "idle data level", int'(b), 0);
      repeat (HALF-1) @(negedge clk);
      check(sdata_out == b, req, "data held across sample edge", int'(sdata_out), int'(b));
    end
  endtask

  task automatic wait_drain(int limit, string req);
    int n = 0;
    while ((exp_q.size() != 0 || nb != 0) && n < limit) begin
      @(negedge clk); n++;
    end
    check(exp_q.size() == 0 && nb == 0, req, "scoreboard drained", exp_q.size(), 0);
  endtask

  initial begin
    int n, falls;
    bit prv;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sdata_out == 1'b0, "R1", "sdata_out", int'(sdata_out), 0);
    check(sclk_out == 1'b1, "R1", "sclk_out", int'(sclk_out), 1);
    check(word_ready == 1'b0, "R1", "word_ready", int'(word_ready), 0);
    check(sclk_oe == 1'b0, "R1", "sclk_oe", int'(sclk_oe), 0);

    // R3 / R2: external clock idling low, three words
    push_word(16'hA5C3); push_word(16'h0001); push_word(16'h8000);
    @(negedge clk) req_in = 1'b1;
    repeat (110) @(negedge clk);
    ext_bits(48, 1, 0, "R3");
    check(exp_q.size() == 0, "R2", "all words sent", exp_q.size(), 0);
    ext_bits(2, 0, 0, "R8");
    @(negedge clk) req_in = 1'b0;
    repeat (4) @(negedge clk);
    ext_bits(1, 0, 0, "R8");

    // R4: external clock idling high
    @(negedge clk) sclk_in = 1'b1;
    set_cfg(2'b01, 8'd3);
    repeat (3) @(negedge clk);
    push_word(16'h1234); push_word(16'hFFFF);
    @(negedge clk) req_in = 1'b1;
    repeat (110) @(negedge clk);
    ext_bits(32, 1, 1, "R4");
    @(negedge clk) req_in = 1'b0;
    repeat (4) @(negedge clk);
    ext_bits(1, 0, 1, "R8");

    // R10: request dropped halfway through a word
    push_word(16'h5A5A); push_word(16'h00FF);
    @(negedge clk) req_in = 1'b1;
    repeat (110) @(negedge clk);
    ext_bits(8, 1, 1, "R10");
    req_in = 1'b0;
    ext_bits(8, 1, 1, "R10");
    check(exp_q.size() == 1, "R10", "first word complete", exp_q.size(), 1);
    ext_bits(2, 0, 1, "R10");
    check(src_q.size() == 1, "R10", "second word left in source", src_q.size(), 1);
    @(negedge clk);
    src_q.delete(); exp_q.delete();

    // R9: idle write applies; R5 / R6 internal clock with divider 2
    set_cfg(2'b10, 8'd2);
    repeat (4) @(negedge clk);
    check(sclk_oe == 1'b1, "R9", "idle config applied", int'(sclk_oe), 1);
    cur_req = "R5";
    push_word(16'hC0DE); push_word(16'h7E81);
    @(negedge clk) req_in = 1'b1;
    n = 0;
    while (sclk_out && n < 400) begin @(negedge clk); n++; end
    check(n >= 192 && n <= 202, "R6", "lead-in cycles", n, 198);
    n = 0;
    while (!sclk_out && n < 50) begin @(negedge clk); n++; end
    check(n == 3, "R5", "half period cycles", n, 3);
    wait_drain(2000, "R5");

    // R8: source empty with request high
    falls = 0; prv = sclk_out;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (prv && !sclk_out) falls++;
      prv = sclk_out;
    end
    check(falls == 0, "R8", "no clock while empty", falls, 0);
    check(sdata_out == 1'b0, "R8", "data low while empty", int'(sdata_out), 0);

    // R9: write while request high must not apply
    set_cfg(2'b00, 8'd2);
    repeat (20) @(negedge clk);
    check(sclk_oe == 1'b1, "R9", "config held while requested", int'(sclk_oe), 1);

    // R7: run-out then pending config applies
    @(negedge clk) req_in = 1'b0;
    n = 0; falls = 0; prv = sclk_out;
    while (sclk_oe && n < 1000) begin
      @(negedge clk); n++;
      if (prv && !sclk_out) falls++;
      prv = sclk_out;
    end
    check(n >= 192 && n <= 206, "R7", "run-out cycles", n, 197);
    check(falls == 0, "R7", "clock high during run-out", falls, 0);

    // R6 / R5 with divider 0 and the mode-11 alias
    set_cfg(2'b11, 8'd0);
    repeat (3) @(negedge clk);
    check(sclk_oe == 1'b1, "R9", "mode 11 selects internal clock", int'(sclk_oe), 1);
    cur_req = "R2";
    push_word(16'h8001); push_word(16'h3C3C);
    @(negedge clk) req_in = 1'b1;
    n = 0;
    while (sclk_out && n < 400) begin @(negedge clk); n++; end
    check(n >= 64 && n <= 70, "R6", "lead-in cycles div0", n, 68);
    wait_drain(2000, "R2");
    @(negedge clk) req_in = 1'b0;
    repeat (100) @(negedge clk);
    check(sclk_out == 1'b1, "R7", "clock parked after run-out", int'(sclk_out), 1);
    check(sdata_out == 1'b0, "R7", "data low after run-out", int'(sdata_out), 0);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule